// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Ninth Data Bit

The block is a full-duplex NRZ serial port for a byte-wide register bus. A transmitter serialises the contents of a one-deep holding register onto the `txd_o` line. A receiver oversamples the `rxd_i` line at sixteen times the bit rate and reassembles frames into a receive data register. Each frame carries one start bit, 8 or 9 data bits sent least-significant first, and one stop bit. In the 9-bit word mode the extra bit travels through two control bits: one the transmitter reads and one the receiver fills.

The transmit and receive rates are generated independently. Both share a coarse prescale selector, and each direction has its own power-of-two rate divider and its own 8-bit extended divider. An extended divider value of zero bypasses that stage. The status register reports the transmit-side conditions (holding register empty, transmission complete) and the receive-side conditions (data ready, idle line, overrun, noise, framing error). A single interrupt line combines these flags under four enables.

Register map (3-bit address): 0 status (read-only), 1 data, 2 control A, 3 control B, 4 rate select, 5 transmit extended divider, 6 receive extended divider.

Top module: `sci_xcvr`

## Requirements
- R1: After reset, status reads C0h, `txd_o` is high, `irq_o` is low, and every writable register is 00h. Status bits: 7 tx-empty, 6 tx-complete, 5 rx-full, 4 idle, 3 overrun, 2 noise, 1 framing error, 0 reads 0.
- R2: A transmitted 8-bit frame is a low start bit, 8 data bits LSB first, then a high stop bit. Each bit lasts 32*P*2^T*E clock cycles, where P is {1,3,4,13} selected by rate-select bits [7:6], T is rate-select bits [5:3], and E is the transmit extended divider (0 counts as 1).
- R3: When control A bit 4 is set, frames carry 9 data bits. Data bit 8 is sent from control A bit 6, and a received bit 8 is readable in control A bit 7.
- R4: A received frame loads the data register and sets status bit 5. Reading the data register clears status bits 5, 4, 3, 2 and 1.
- R5: When a frame completes while status bit 5 is set, status bit 3 is set and the earlier data is kept.
- R6: Each bit is decided by a majority of samples 8, 9 and 10 of its sixteen. If these samples disagree anywhere in an accepted frame, status bit 2 is set and the data still decodes correctly.
- R7: A stop bit sampled low sets status bit 1.
- R8: After a received frame, a high line for one whole frame time sets status bit 4. Without a new frame it is not set again.
- R9: Writing the data register clears status bits 7 and 6. Bit 7 returns when the value moves into the shifter. Bit 6 returns when the shifter finishes and nothing is pending.
- R10: The receive bit time is 32*P*2^R*E, where R is rate-select bits [2:0] and E is the receive extended divider (0 counts as 1). It is independent of the transmit settings.
- R11: `irq_o` = (B7 & tx-empty) | (B6 & tx-complete) | (B5 & (rx-full | overrun)) | (B4 & idle), where Bn are control B bits.
- R12: Control B bit 3 enables the transmitter: while it is clear, written data stays pending and `txd_o` stays high. Control B bit 2 enables the receiver: while it is clear, frames on `rxd_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects on data register) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench places a single-tick glitch on the middle sample of one data bit only. A receiver that uses a single sample, or that votes on the wrong window, then returns corrupt data or leaves the noise flag clear. It lets a second frame arrive before the first is read, so a design that overwrites the data register on overrun shows the second byte. It checks the idle flag twice after one frame, to catch a flag that re-arms on a quiet line. It checks the transmit flags one cycle after a write, to catch a tx-complete that rises while data is still pending. Non-default prescale, divider and extended-divider settings on each side expose a design that shares one rate between the two directions.

// File: rtl/sci_pkg.sv
package sci_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTLA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTLB  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RATE  = 3'd4;
  localparam logic [ADDR_W-1:0] A_TXEXT = 3'd5;
  localparam logic [ADDR_W-1:0] A_RXEXT = 3'd6;
  localparam int OVS = 16;
  typedef enum logic {RX_IDLE, RX_RUN} rx_state_e;
endpackage

// File: rtl/sci_baud_gen.sv
module sci_baud_gen #(
  parameter int CNT_W = 22
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [1:0] pre_sel_i,
  input  logic [2:0] rate_i,
  input  logic [7:0] ext_i,
  output logic       tick_o
);
  logic [CNT_W-1:0] cnt, prod, lim;
  logic [3:0]       pre;

  always_comb begin
    case (pre_sel_i)
      2'd0:    pre = 4'd1;
      2'd1:    pre = 4'd3;
      2'd2:    pre = 4'd4;
      default: pre = 4'd13;
    endcase
    prod = CNT_W'(pre) * CNT_W'((ext_i == 8'd0) ? 8'd1 : ext_i);
    prod = prod << rate_i;
    prod = prod << 1;
    lim  = prod - CNT_W'(1);
  end

  assign tick_o = !clr_i && (cnt >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt <= '0;
    else if (clr_i || tick_o) cnt <= '0;
    else                     cnt <= cnt + CNT_W'(1);
  end

  // one sub-bit tick is never followed by another in the next cycle
  p_tick_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sci_tx_engine.sv
module sci_tx_engine
  import sci_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic       nine_i,
  input  logic [8:0] data_i,
  output logic       txd_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int PH_W = $clog2(OVS);
  logic [10:0]     sh;
  logic [PH_W-1:0] ph;
  logic [3:0]      left;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh <= '1; ph <= '0; left <= '0; busy_o <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        sh     <= nine_i ? {1'b1, data_i, 1'b0} : {2'b11, data_i[7:0], 1'b0};
        left   <= nine_i ? 4'd11 : 4'd10;
        ph     <= '0;
        busy_o <= 1'b1;
      end else if (busy_o && tick_i) begin
        if (ph == PH_W'(OVS-1)) begin
          ph   <= '0;
          sh   <= {1'b1, sh[10:1]};
          left <= left - 4'd1;
          if (left == 4'd1) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end
        end else begin
          ph <= ph + PH_W'(1);
        end
      end
    end
  end

  assign txd_o = busy_o ? sh[0] : 1'b1;

  // the last bit shifted out before going idle is the high stop bit
  p_stop_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tick_i && ph == PH_W'(OVS-1) && left == 4'd1) |-> txd_o);
endmodule

// File: rtl/sci_rx_engine.sv
module sci_rx_engine
  import sci_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       rxd_i,
  input  logic       nine_i,
  input  logic       tick_i,
  output logic       gen_clr_o,
  output logic       valid_o,
  output logic [8:0] data_o,
  output logic       noise_o,
  output logic       ferr_o,
  output logic       idle_o
);
  localparam int PH_W = $clog2(OVS);
  localparam int MID  = OVS / 2;   // samples MID-1..MID+1 (0-based) are voted

  rx_state_e       st;
  logic [1:0]      sync;
  logic            rxs, s_a, s_b, vote, dis, nacc, armed;
  logic [PH_W-1:0] ph;
  logic [3:0]      idx, last;
  logic [8:0]      sh;
  logic [7:0]      idle_cnt, frame_ticks;

  assign rxs         = sync[1];
  assign vote        = (s_a & s_b) | (s_a & rxs) | (s_b & rxs);
  assign dis         = !((s_a == s_b) && (s_b == rxs));
  assign last        = nine_i ? 4'd10 : 4'd9;
  assign frame_ticks = nine_i ? 8'(OVS*11) : 8'(OVS*10);
  assign gen_clr_o   = (st == RX_IDLE) && en_i && !rxs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync <= 2'b11;
    else         sync <= {sync[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= RX_IDLE; ph <= '0; idx <= '0; sh <= '0; s_a <= 1'b1; s_b <= 1'b1;
      nacc <= 1'b0; armed <= 1'b0; idle_cnt <= '0;
      valid_o <= 1'b0; data_o <= '0; noise_o <= 1'b0; ferr_o <= 1'b0; idle_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      idle_o  <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (gen_clr_o) begin
            st <= RX_RUN; ph <= '0; idx <= '0; nacc <= 1'b0; idle_cnt <= '0;
          end else if (tick_i && armed) begin
            if (idle_cnt == frame_ticks - 8'd1) begin
              idle_o <= 1'b1; armed <= 1'b0; idle_cnt <= '0;
            end else begin
              idle_cnt <= idle_cnt + 8'd1;
            end
          end
        end
        RX_RUN: begin
          if (!en_i) begin
            st <= RX_IDLE;
          end else if (tick_i) begin
            ph <= ph + PH_W'(1);
            if (ph == PH_W'(MID-1)) s_a <= rxs;
            if (ph == PH_W'(MID))   s_b <= rxs;
            if (ph == PH_W'(MID+1)) begin
              nacc <= nacc | dis;
              if (idx == 4'd0) begin
                if (vote) st <= RX_IDLE;   // false start
              end else if (idx == last) begin
                valid_o  <= 1'b1;
                data_o   <= nine_i ? sh : {1'b0, sh[8:1]};
                ferr_o   <= !vote;
                noise_o  <= nacc | dis;
                st       <= RX_IDLE;
                armed    <= 1'b1;
                idle_cnt <= '0;
              end else begin
                sh <= {vote, sh[8:1]};
              end
            end
            if (ph == PH_W'(OVS-1)) idx <= idx + 4'd1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  p_valid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_idle_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |=> !idle_o);
endmodule

// File: rtl/sci_xcvr.sv
module sci_xcvr
  import sci_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              irq_o
);
  logic       word9, tx_b8, rx_b8;
  logic [5:0] ctlb;          // {tie, tcie, rie, ilie, te, re}
  logic [7:0] rate, tx_ext, rx_ext, tdr, rdr;
  logic       tdre, tc, rdrf, idle_f, ovr, nf, fe;
  logic       tx_tick, tx_busy, tx_done, tx_start;
  logic       rx_tick, rx_clr, rx_valid, rx_noise, rx_ferr, rx_idle;
  logic [8:0] rx_data;
  logic       wr_data, rd_data, te, re;

  assign te       = ctlb[1];
  assign re       = ctlb[0];
  assign wr_data  = wr_en_i && addr_i == A_DATA;
  assign rd_data  = rd_en_i && addr_i == A_DATA;
  assign tx_start = te && !tdre && !tx_busy;

  sci_baud_gen #(.CNT_W(CNT_W)) i_tx_gen (
    .clk_i, .rst_ni, .clr_i(!tx_busy), .pre_sel_i(rate[7:6]),
    .rate_i(rate[5:3]), .ext_i(tx_ext), .tick_o(tx_tick));

  sci_baud_gen #(.CNT_W(CNT_W)) i_rx_gen (
    .clk_i, .rst_ni, .clr_i(rx_clr), .pre_sel_i(rate[7:6]),
    .rate_i(rate[2:0]), .ext_i(rx_ext), .tick_o(rx_tick));

  sci_tx_engine i_tx (
    .clk_i, .rst_ni, .tick_i(tx_tick), .start_i(tx_start), .nine_i(word9),
    .data_i({tx_b8, tdr}), .txd_o, .busy_o(tx_busy), .done_o(tx_done));

  sci_rx_engine i_rx (
    .clk_i, .rst_ni, .en_i(re), .rxd_i, .nine_i(word9), .tick_i(rx_tick),
    .gen_clr_o(rx_clr), .valid_o(rx_valid), .data_o(rx_data),
    .noise_o(rx_noise), .ferr_o(rx_ferr), .idle_o(rx_idle));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word9 <= 1'b0; tx_b8 <= 1'b0; ctlb <= '0; rate <= '0;
      tx_ext <= '0; rx_ext <= '0; tdr <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_DATA:  tdr <= wdata_i;
        A_CTLA:  begin tx_b8 <= wdata_i[6]; word9 <= wdata_i[4]; end
        A_CTLB:  ctlb <= wdata_i[7:2];
        A_RATE:  rate <= wdata_i;
        A_TXEXT: tx_ext <= wdata_i;
        A_RXEXT: rx_ext <= wdata_i;
        default: ;
      endcase
    end
  end

  // transmit flags: a write outranks a same-cycle transfer to the shifter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdre <= 1'b1; tc <= 1'b1;
    end else if (wr_data) begin
      tdre <= 1'b0; tc <= 1'b0;
    end else begin
      if (tx_start) tdre <= 1'b1;
      if (tx_done && tdre) tc <= 1'b1;
    end
  end

  // receive flags: a completing frame outranks a same-cycle read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdrf <= 1'b0; ovr <= 1'b0; nf <= 1'b0; fe <= 1'b0; idle_f <= 1'b0;
      rdr <= '0; rx_b8 <= 1'b0;
    end else begin
      if (rd_data) begin
        rdrf <= 1'b0; ovr <= 1'b0; nf <= 1'b0; fe <= 1'b0; idle_f <= 1'b0;
      end
      if (rx_idle) idle_f <= 1'b1;
      if (rx_valid) begin
        if (rdrf && !rd_data) begin
          ovr <= 1'b1;
        end else begin
          rdr <= rx_data[7:0]; rx_b8 <= rx_data[8];
          rdrf <= 1'b1; nf <= rx_noise; fe <= rx_ferr;
        end
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_STAT:  rdata_o = {tdre, tc, rdrf, idle_f, ovr, nf, fe, 1'b0};
      A_DATA:  rdata_o = rdr;
      A_CTLA:  rdata_o = {rx_b8, tx_b8, 1'b0, word9, 4'b0};
      A_CTLB:  rdata_o = {ctlb, 2'b00};
      A_RATE:  rdata_o = rate;
      A_TXEXT: rdata_o = tx_ext;
      A_RXEXT: rdata_o = rx_ext;
      default: rdata_o = 8'h00;
    endcase
  end

  assign irq_o = (ctlb[5] & tdre) | (ctlb[4] & tc) |
                 (ctlb[3] & (rdrf | ovr)) | (ctlb[2] & idle_f);

  p_wr_clears_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> (!tdre && !tc));
  p_overrun_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid && rdrf && !rd_data) |=> (ovr && rdrf));
  p_read_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !rx_valid) |=> (!rdrf && !ovr));
  p_tc_needs_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc) |-> tdre);
endmodule

// File: tb/test_sci_xcvr.sv
module test_sci_xcvr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, rxd = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       txd, irq;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  sci_xcvr i_sci_xcvr (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd), .irq_o(irq));

  // {nine, data9, rate, rx_ext}
  localparam int NV = 6;
  localparam logic [25:0] RXV [NV] = '{
    {1'b0, 9'h055, 8'h00, 8'd0},
    {1'b1, 9'h1A3, 8'h00, 8'd0},
    {1'b0, 9'h0C3, 8'h01, 8'd0},
    {1'b0, 9'h00F, 8'h40, 8'd0},
    {1'b1, 9'h0FE, 8'h00, 8'd3},
    {1'b0, 9'h080, 8'h02, 8'd2}
  };

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic int bit_time(input logic [1:0] ps, input logic [2:0] r, input logic [7:0] e);
    int p;
    case (ps) 2'd0: p = 1; 2'd1: p = 3; 2'd2: p = 4; default: p = 13; endcase
    return 32 * p * (1 << r) * ((e == 0) ? 1 : int'(e));
  endfunction

  // glitch_bit: frame bit index whose middle sample gets inverted (-1: none)
  task automatic send(input bit nine, input logic [8:0] d, input int bp,
                      input int glitch_bit, input bit stop_v);
    logic [10:0] fr;
    int nb;
    nb = nine ? 11 : 10;
    fr = nine ? {stop_v, d, 1'b0} : {1'b1, stop_v, d[7:0], 1'b0};
    for (int b = 0; b < nb; b++)
      for (int c = 0; c < bp; c++) begin
        @(negedge clk);
        rxd = (b == glitch_bit && c >= bp*17/32 && c < bp*19/32) ? ~fr[b] : fr[b];
      end
    @(negedge clk); rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic grab_tx(input int nb, input int bp, output logic [8:0] d, output logic stp);
    int to;
    to = 0;
    while (txd === 1'b1 && to < 5000) begin @(negedge clk); to++; end
    repeat (bp/2) @(negedge clk);
    d = '0;
    for (int i = 0; i < nb; i++) begin repeat (bp) @(negedge clk); d[i] = txd; end
    repeat (bp) @(negedge clk);
    stp = txd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [8:0] td;
    logic       ts;
    bit         hi_ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); check("R1 status", v, 8'hC0);
    check("R1 txd", txd, 1);
    check("R1 irq", irq, 0);
    rd(3'd4, v); check("R1 rate", v, 8'h00);

    // R4 R3 R10 receive vectors
    wr(3'd3, 8'h0C);
    for (int i = 0; i < NV; i++) begin
      logic        nine;
      logic [8:0]  d;
      logic [7:0]  rt, ex;
      {nine, d, rt, ex} = RXV[i];
      wr(3'd2, {3'b000, nine, 4'b0});
      wr(3'd4, rt);
      wr(3'd6, ex);
      send(nine, d, bit_time(rt[7:6], rt[2:0], ex), -1, 1'b1);
      rd(3'd0, v); check("R4 rx status", v, 8'hE0);
      rd(3'd2, v); check("R3 rx bit8", v, {nine & d[8], 2'b00, nine, 4'b0});
      rd(3'd1, v); check("R10 rx data", v, d[7:0]);
      rd(3'd0, v); check("R4 cleared", v, 8'hC0);
    end
    wr(3'd2, 8'h00); wr(3'd4, 8'h00); wr(3'd6, 8'h00);

    // R5 overrun keeps first byte
    send(1'b0, 9'h011, 32, -1, 1'b1);
    send(1'b0, 9'h022, 32, -1, 1'b1);
    rd(3'd0, v); check("R5 ovr flag", v & 8'h28, 8'h28);
    rd(3'd1, v); check("R5 kept data", v, 8'h11);

    // R6 noise on middle sample of bit 3, bit time 128
    wr(3'd4, 8'h02);
    send(1'b0, 9'h0A5, 128, 3, 1'b1);
    rd(3'd0, v); check("R6 noise flag", v & 8'h26, 8'h24);
    rd(3'd1, v); check("R6 voted data", v, 8'hA5);
    wr(3'd4, 8'h00);

    // R7 framing error
    send(1'b0, 9'h03C, 32, -1, 1'b0);
    rd(3'd0, v); check("R7 ferr flag", v & 8'h22, 8'h22);
    rd(3'd1, v);

    // R8 idle flag, once
    repeat (400) @(negedge clk);
    rd(3'd1, v);
    send(1'b0, 9'h05A, 32, -1, 1'b1);
    rd(3'd0, v); check("R8 not yet idle", v & 8'h10, 8'h00);
    repeat (400) @(negedge clk);
    rd(3'd0, v); check("R8 idle set", v & 8'h10, 8'h10);
    rd(3'd1, v);
    repeat (400) @(negedge clk);
    rd(3'd0, v); check("R8 idle not re-set", v & 8'h10, 8'h00);

    // R2 R9 transmit 8-bit, default rate
    wr(3'd1, 8'h3C);
    rd(3'd0, v); check("R9 after write", v & 8'hC0, 8'h80);
    grab_tx(8, 32, td, ts);
    check("R2 tx data", td, 9'h03C);
    check("R2 tx stop", ts, 1);
    repeat (40) @(negedge clk);
    rd(3'd0, v); check("R9 tc back", v & 8'hC0, 8'hC0);

    // R10 independent tx rate: tx div 2, ext 3 -> 192
    wr(3'd4, 8'h08); wr(3'd5, 8'd3);
    wr(3'd1, 8'h96);
    grab_tx(8, bit_time(2'd0, 3'd1, 8'd3), td, ts);
    check("R10 tx slow data", td, 9'h096);
    repeat (300) @(negedge clk);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);

    // R3 transmit 9-bit
    wr(3'd2, 8'h50);
    wr(3'd1, 8'h5A);
    grab_tx(9, 32, td, ts);
    check("R3 tx nine", td, 9'h15A);
    check("R3 tx stop", ts, 1);
    repeat (40) @(negedge clk);
    wr(3'd2, 8'h00);

    // R12 transmitter disabled
    wr(3'd3, 8'h04);
    wr(3'd1, 8'hA1);
    hi_ok = 1'b1;
    for (int c = 0; c < 400; c++) begin @(negedge clk); if (txd !== 1'b1) hi_ok = 1'b0; end
    check("R12 txd held high", hi_ok, 1);
    rd(3'd0, v); check("R12 data pending", v & 8'hC0, 8'h00);
    wr(3'd3, 8'h0C);
    grab_tx(8, 32, td, ts);
    check("R12 tx after enable", td, 9'h0A1);
    repeat (40) @(negedge clk);

    // R12 receiver disabled
    wr(3'd3, 8'h08);
    send(1'b0, 9'h077, 32, -1, 1'b1);
    rd(3'd0, v); check("R12 rx ignored", v & 8'h20, 8'h00);

    // R11 interrupt
    wr(3'd3, 8'h88);
    #1 check("R11 irq tx-empty", irq, 1);
    wr(3'd3, 8'h2C);
    #1 check("R11 irq off", irq, 0);
    send(1'b0, 9'h044, 32, -1, 1'b1);
    check("R11 irq rx-full", irq, 1);
    rd(3'd1, v);
    #1 check("R11 irq cleared", irq, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule